// File: doc/BRIEF.md
# MIDI Host Pass-Through Controller

This block sits on a byte-wide, I/O-mapped host bus and connects it to a serial MIDI link. It occupies two consecutive addresses. The data port sits at the base address. The command/status port sits one address above it. After reset the controller is in command mode. In that mode every command written to it is acknowledged, and data-port writes and arriving serial bytes are thrown away. Writing the pass-through command `3Fh` moves it into pass-through mode. From then on, bytes written to the data port leave on `midi_out` unchanged, and bytes arriving on `midi_in` are offered unchanged at the data port. In pass-through mode only the reset command `FFh` has any effect. It returns the controller to command mode.

The serial side is a fixed 8-N-1 UART. The bit rate is derived from parameters, and the defaults give 31250 baud from a 50 MHz clock. The transmit path holds one byte and reports "not ready" until the serialiser has taken it. The receive path holds one byte and raises the interrupt request while that byte is unread. Host strobes are sampled with the block clock, and each falling edge of a strobe makes exactly one access.

Top module: `mpt_midi_passthru`

## Requirements
- R1: After reset the controller is in command mode, `host_irq` is low, `midi_out` idles high, and a status read returns 80h.
- R2: In command mode, every write to the command port loads the acknowledge byte FEh into the receive register, which raises `host_irq` and clears status bit 7. Only code 3Fh also switches the controller to pass-through mode.
- R3: In command mode, data-port writes send nothing, and bytes arriving on `midi_in` are discarded.
- R4: In pass-through mode, a data-port write is sent on `midi_out` as a start bit (0), eight data bits LSB first, and a stop bit (1). Each bit lasts CLK_HZ/BAUD clocks, and the byte arrives unchanged.
- R5: Status bit 6 is 1 while the one-byte transmit holding register is full. A data write made while it is full is dropped.
- R6: In pass-through mode, a correctly framed byte received on `midi_in` is placed unchanged in the receive register. It raises `host_irq` and clears status bit 7.
- R7: A data-port read returns the receive register and, if a byte was pending, clears `host_irq` and sets status bit 7.
- R8: In pass-through mode, command-port writes other than FFh are ignored. No acknowledge is queued and the mode is unchanged.
- R9: Command FFh in pass-through mode returns the controller to command mode and queues the acknowledge FEh.
- R10: A serial byte that arrives while the receive register is full is discarded, and the older byte is kept. An acknowledge always overwrites a pending byte.
- R11: Accesses to addresses other than the base address and the base address + 1 have no effect, and `host_rd_en` stays low for them.
- R12: A received frame whose stop bit is 0 is discarded. The receiver then waits for the line to return high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write data |
| host_iow_n | input | 1 | Active-low I/O write strobe |
| host_ior_n | input | 1 | Active-low I/O read strobe |
| host_rdata | output | 8 | Read data, valid from the clock after the read strobe falls |
| host_rd_en | output | 1 | High while a read strobe addresses one of the two ports |
| host_irq | output | 1 | Interrupt request: a received byte is pending |
| midi_in | input | 1 | Serial MIDI receive line |
| midi_out | output | 1 | Serial MIDI transmit line |

## Verification
The assertions assume that the host strobes are synchronous to `clk`. They also assume that the address and write data are stable for the whole cycle in which a strobe is first seen low, and that read and write strobes are never low together. The bench drives every bus access on the falling clock edge, holds the address and data across the strobe, and returns the strobe high for at least one full cycle between accesses. Each serial frame it injects has exact bit lengths, and the line idles high between frames, except in the one case where the stop bit is deliberately driven low.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

  typedef enum logic {
    MODE_CMD  = 1'b0,
    MODE_UART = 1'b1
  } mpt_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_BREAK = 3'd4
  } mpt_rx_state_e;

  localparam logic [7:0] CODE_ENTER_UART = 8'h3F;
  localparam logic [7:0] CODE_RESET      = 8'hFF;
  localparam logic [7:0] CODE_ACK        = 8'hFE;

endpackage

// File: rtl/mpt_host_if.sv
module mpt_host_if #(
  parameter logic [15:0] BASE_ADDR = 16'h0330
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        iow_n,
  input  logic        ior_n,
  input  logic [7:0]  status_byte,
  input  logic [7:0]  data_byte,
  output logic        data_wr,
  output logic        cmd_wr,
  output logic        data_rd,
  output logic [7:0]  wr_byte,
  output logic [7:0]  rdata,
  output logic        rd_en
);

  localparam logic [15:0] CMD_ADDR = BASE_ADDR + 16'd1;

  logic       iow_q, ior_q;
  logic       iow_d, ior_d;
  logic [7:0] rdata_q, rdata_d;
  logic       hit_data, hit_cmd, wr_edge, rd_edge, status_rd;

  assign hit_data = (addr == BASE_ADDR);
  assign hit_cmd  = (addr == CMD_ADDR);
  assign wr_edge  = !iow_n && iow_q;
  assign rd_edge  = !ior_n && ior_q;

  assign data_wr   = wr_edge && hit_data;
  assign cmd_wr    = wr_edge && hit_cmd;
  assign data_rd   = rd_edge && hit_data;
  assign status_rd = rd_edge && hit_cmd;
  assign wr_byte   = wdata;
  assign rd_en     = !ior_n && (hit_data || hit_cmd);
  assign rdata     = rdata_q;

  always_comb begin
    iow_d   = iow_n;
    ior_d   = ior_n;
    rdata_d = rdata_q;
    if (data_rd)   rdata_d = data_byte;
    if (status_rd) rdata_d = status_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iow_q   <= 1'b1;
      ior_q   <= 1'b1;
      rdata_q <= 8'h00;
    end else begin
      iow_q   <= iow_d;
      ior_q   <= ior_d;
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/mpt_cmd_ctrl.sv
module mpt_cmd_ctrl
  import mpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       data_wr,
  input  logic       data_rd,
  input  logic [7:0] wr_byte,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_hold_full,
  output mpt_mode_e  mode,
  output logic       tx_load,
  output logic       rx_full,
  output logic [7:0] rx_byte,
  output logic [7:0] status_byte
);

  mpt_mode_e  mode_q, mode_d;
  logic       full_q, full_d;
  logic [7:0] byte_q, byte_d;
  logic       cmd_accept;

  assign cmd_accept  = cmd_wr && ((mode_q == MODE_CMD) || (wr_byte == CODE_RESET));
  assign tx_load     = data_wr && (mode_q == MODE_UART);
  assign status_byte = {!full_q, tx_hold_full, 6'b000000};
  assign mode        = mode_q;
  assign rx_full     = full_q;
  assign rx_byte     = byte_q;

  always_comb begin
    mode_d = mode_q;
    full_d = full_q;
    byte_d = byte_q;
    if (rx_valid && (mode_q == MODE_UART) && (!full_q || data_rd)) begin
      full_d = 1'b1;
      byte_d = rx_data;
    end else if (data_rd) begin
      full_d = 1'b0;
    end
    if (cmd_accept) begin
      full_d = 1'b1;
      byte_d = CODE_ACK;
      if (mode_q == MODE_UART)
        mode_d = MODE_CMD;
      else if (wr_byte == CODE_ENTER_UART)
        mode_d = MODE_UART;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CMD;
      full_q <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      mode_q <= mode_d;
      full_q <= full_d;
      byte_q <= byte_d;
    end
  end

endmodule

// File: rtl/mpt_uart_tx.sv
module mpt_uart_tx #(
  parameter int CLKS_PER_BIT = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  output logic       hold_full,
  output logic [7:0] hold_data,
  output logic       busy,
  output logic       txd
);

  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(CLKS_PER_BIT - 1);
  localparam logic [3:0]    LAST_BIT = 4'd9;

  logic          full_q, full_d;
  logic [7:0]    hold_q, hold_d;
  logic          busy_q, busy_d;
  logic [9:0]    shift_q, shift_d;
  logic [3:0]    bit_q, bit_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    full_d  = full_q;
    hold_d  = hold_q;
    busy_d  = busy_q;
    shift_d = shift_q;
    bit_d   = bit_q;
    cnt_d   = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) begin
        if (bit_q == LAST_BIT) begin
          busy_d = 1'b0;
        end else begin
          shift_d = {1'b1, shift_q[9:1]};
          bit_d   = bit_q + 4'd1;
          cnt_d   = CNT_TOP;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (full_q) begin
      busy_d  = 1'b1;
      shift_d = {1'b1, hold_q, 1'b0};
      bit_d   = 4'd0;
      cnt_d   = CNT_TOP;
      full_d  = 1'b0;
    end
    if (load && !full_q) begin
      full_d = 1'b1;
      hold_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      hold_q  <= 8'h00;
      busy_q  <= 1'b0;
      shift_q <= 10'h3FF;
      bit_q   <= 4'd0;
      cnt_q   <= '0;
    end else begin
      full_q  <= full_d;
      hold_q  <= hold_d;
      busy_q  <= busy_d;
      shift_q <= shift_d;
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
    end
  end

  assign hold_full = full_q;
  assign hold_data = hold_q;
  assign busy      = busy_q;
  assign txd       = busy_q ? shift_q[0] : 1'b1;

endmodule

// File: rtl/mpt_uart_rx.sv
module mpt_uart_rx
  import mpt_pkg::*;
#(
  parameter int CLKS_PER_BIT = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       valid,
  output logic [7:0] data
);

  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] CNT_TOP  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(CLKS_PER_BIT / 2 - 1);

  logic          sync1_q, sync2_q;
  mpt_rx_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sr_q, sr_d;
  logic          valid_q, valid_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sr_d    = sr_q;
    valid_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (!sync2_q) begin
          state_d = RX_START;
          cnt_d   = CNT_HALF;
        end
      end
      RX_START: begin
        if (cnt_q == '0) begin
          if (!sync2_q) begin
            state_d = RX_DATA;
            cnt_d   = CNT_TOP;
            bit_d   = 3'd0;
          end else begin
            state_d = RX_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      RX_DATA: begin
        if (cnt_q == '0) begin
          sr_d  = {sync2_q, sr_q[7:1]};
          cnt_d = CNT_TOP;
          if (bit_q == 3'd7) state_d = RX_STOP;
          else               bit_d   = bit_q + 3'd1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      RX_STOP: begin
        if (cnt_q == '0) begin
          valid_d = sync2_q;
          state_d = sync2_q ? RX_IDLE : RX_BREAK;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      RX_BREAK: begin
        if (sync2_q) state_d = RX_IDLE;
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= 3'd0;
      sr_q    <= 8'h00;
      valid_q <= 1'b0;
    end else begin
      sync1_q <= rxd;
      sync2_q <= sync1_q;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sr_q    <= sr_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;
  assign data  = sr_q;

endmodule

// File: rtl/mpt_midi_passthru.sv
module mpt_midi_passthru
  import mpt_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0330,
  parameter int          CLK_HZ    = 50_000_000,
  parameter int          BAUD      = 31_250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] host_addr,
  input  logic [7:0]  host_wdata,
  input  logic        host_iow_n,
  input  logic        host_ior_n,
  output logic [7:0]  host_rdata,
  output logic        host_rd_en,
  output logic        host_irq,
  input  logic        midi_in,
  output logic        midi_out
);

  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

  logic       rst_meta_q, rst_sync_n;
  logic       data_wr, cmd_wr, data_rd;
  logic [7:0] wr_byte, status_byte, rx_byte, rx_data, tx_hold_data;
  logic       tx_load, tx_hold_full, tx_busy, rx_valid, rx_full;
  mpt_mode_e  mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mpt_host_if #(.BASE_ADDR(BASE_ADDR)) u_host (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .iow_n      (host_iow_n),
    .ior_n      (host_ior_n),
    .status_byte(status_byte),
    .data_byte  (rx_byte),
    .data_wr    (data_wr),
    .cmd_wr     (cmd_wr),
    .data_rd    (data_rd),
    .wr_byte    (wr_byte),
    .rdata      (host_rdata),
    .rd_en      (host_rd_en)
  );

  mpt_cmd_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_wr      (cmd_wr),
    .data_wr     (data_wr),
    .data_rd     (data_rd),
    .wr_byte     (wr_byte),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .tx_hold_full(tx_hold_full),
    .mode        (mode),
    .tx_load     (tx_load),
    .rx_full     (rx_full),
    .rx_byte     (rx_byte),
    .status_byte (status_byte)
  );

  mpt_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tx_load),
    .load_data(wr_byte),
    .hold_full(tx_hold_full),
    .hold_data(tx_hold_data),
    .busy     (tx_busy),
    .txd      (midi_out)
  );

  mpt_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .rxd  (midi_in),
    .valid(rx_valid),
    .data (rx_data)
  );

  assign host_irq = rx_full;

endmodule

// File: rtl/mpt_midi_passthru_chk.sv
module mpt_midi_passthru_chk
  import mpt_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0330
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [15:0] host_addr,
  input logic [7:0]  host_wdata,
  input logic        host_iow_n,
  input logic        host_ior_n,
  input logic        host_irq,
  input logic        midi_out,
  input mpt_mode_e   mode,
  input logic [7:0]  rx_byte,
  input logic        rx_valid,
  input logic        tx_hold_full,
  input logic [7:0]  tx_hold_data,
  input logic        tx_busy
);

  logic cmd_port_wr, data_port_wr, data_port_rd;
  assign cmd_port_wr  = !host_iow_n && (host_addr == BASE_ADDR + 16'd1);
  assign data_port_wr = !host_iow_n && (host_addr == BASE_ADDR);
  assign data_port_rd = !host_ior_n && (host_addr == BASE_ADDR);

  // R2: a command in command mode leaves an acknowledge pending
  p_ack_queued_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_port_wr && $past(host_iow_n) && mode == MODE_CMD) |=> (host_irq && rx_byte == CODE_ACK));

  // R2: entry code switches to pass-through
  p_enter_uart_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_port_wr && $past(host_iow_n) && mode == MODE_CMD && host_wdata == CODE_ENTER_UART) |=> (mode == MODE_UART));

  // R8: non-reset commands leave pass-through mode in place
  p_uart_ignores_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_port_wr && $past(host_iow_n) && mode == MODE_UART && host_wdata != CODE_RESET) |=> (mode == MODE_UART));

  // R9: reset code leaves pass-through mode with an acknowledge
  p_reset_cmd_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_port_wr && $past(host_iow_n) && mode == MODE_UART && host_wdata == CODE_RESET) |=> (mode == MODE_CMD && host_irq && rx_byte == CODE_ACK));

  // R7: a data read with no concurrent arrival drops the request
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_port_rd && $past(host_ior_n) && !rx_valid) |=> !host_irq);

  // R5: a held byte is not overwritten by a further write
  p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_hold_full && data_port_wr) |=> $stable(tx_hold_data));

  // R4: the line only drops for a start bit of an active frame
  p_start_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(midi_out) |-> tx_busy);

  // R3: data writes in command mode do not fill the holding register
  p_cmd_no_tx_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (data_port_wr && mode == MODE_CMD && !tx_hold_full) |=> !tx_hold_full);

endmodule

bind mpt_midi_passthru mpt_midi_passthru_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_iow_n  (host_iow_n),
  .host_ior_n  (host_ior_n),
  .host_irq    (host_irq),
  .midi_out    (midi_out),
  .mode        (mode),
  .rx_byte     (rx_byte),
  .rx_valid    (rx_valid),
  .tx_hold_full(tx_hold_full),
  .tx_hold_data(tx_hold_data),
  .tx_busy     (tx_busy)
);

// File: tb/mpt_midi_passthru_tb.sv
`timescale 1ns/1ps
module mpt_midi_passthru_tb;

  localparam logic [15:0] BASE = 16'h0330;
  localparam int CLK_HZ = 50_000_000;
  localparam int BAUD   = 3_125_000;
  localparam int CPB    = CLK_HZ / BAUD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_addr = 16'h0000;
  logic [7:0]  host_wdata = 8'h00;
  logic        host_iow_n = 1'b1;
  logic        host_ior_n = 1'b1;
  logic [7:0]  host_rdata;
  logic        host_rd_en;
  logic        host_irq;
  logic        midi_in = 1'b1;
  logic        midi_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bit       m_uart = 0;
  bit       m_full = 0;
  bit [7:0] m_byte = 8'h00;
  bit       m_known = 0;
  bit [7:0] exp_tx[$];
  bit [8:0] got_tx[$];

  always #10 clk = ~clk;

  mpt_midi_passthru #(.BASE_ADDR(BASE), .CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_iow_n(host_iow_n), .host_ior_n(host_ior_n), .host_rdata(host_rdata),
    .host_rd_en(host_rd_en), .host_irq(host_irq), .midi_in(midi_in), .midi_out(midi_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt against the model
  always @(negedge clk) begin
    #2;
    if (m_known && !finished) check(host_irq == m_full, "R6/R7 irq model", host_irq, m_full);
  end

  // transmit frame capture: {stop, data}
  initial begin
    forever begin
      @(negedge midi_out);
      begin
        bit [7:0] d;
        bit st;
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          d[i] = midi_out;
        end
        repeat (CPB) @(negedge clk);
        st = midi_out;
        got_tx.push_back({st, d});
      end
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_iow_n = 1'b0;
    @(negedge clk);
    if (a == BASE + 16'd1) begin
      if (!m_uart || d == 8'hFF) begin
        m_full = 1; m_byte = 8'hFE;
        if (m_uart) m_uart = 0;
        else if (d == 8'h3F) m_uart = 1;
      end
    end
    host_iow_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    host_addr = a; host_ior_n = 1'b0;
    @(negedge clk);
    d = host_rdata; en = host_rd_en;
    if (a == BASE) m_full = 0;
    host_ior_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_serial(input logic [7:0] d, input logic stop);
    m_known = 0;
    @(negedge clk);
    midi_in = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      midi_in = d[i];
      repeat (CPB) @(negedge clk);
    end
    midi_in = stop;
    repeat (CPB) @(negedge clk);
    midi_in = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    if (m_uart && stop && !m_full) begin m_full = 1; m_byte = d; end
    m_known = 1;
  endtask

  task automatic tx_settle_and_compare(input string req);
    repeat (24 * CPB) @(negedge clk);
    check(got_tx.size() == exp_tx.size(), req, got_tx.size(), exp_tx.size());
    while (got_tx.size() > 0 && exp_tx.size() > 0) begin
      bit [8:0] g;
      bit [7:0] e;
      g = got_tx.pop_front();
      e = exp_tx.pop_front();
      check(g == {1'b1, e}, req, g, {1'b1, e});
    end
    got_tx.delete();
    exp_tx.delete();
  endtask

  task automatic read_status(input bit [7:0] exp, input string req);
    logic [7:0] d; logic en;
    bus_read(BASE + 16'd1, d, en);
    check(d == exp, req, d, exp);
  endtask

  task automatic read_data(input bit [7:0] exp, input string req);
    logic [7:0] d; logic en;
    bus_read(BASE, d, en);
    check(d == exp, req, d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_known = 1;

    // R1: reset state
    check(host_irq == 1'b0, "R1 irq", host_irq, 0);
    check(midi_out == 1'b1, "R1 idle line", midi_out, 1);
    read_status(8'h80, "R1 status");

    // R3: command mode drops data writes and serial input
    bus_write(BASE, 8'h55);
    send_serial(8'h12, 1'b1);
    check(host_irq == 1'b0, "R3 rx discarded", host_irq, 0);
    tx_settle_and_compare("R3 no tx in command mode");

    // R2: arbitrary command acknowledged, stays in command mode
    bus_write(BASE + 16'd1, 8'h99);
    check(host_irq == 1'b1, "R2 ack irq", host_irq, 1);
    read_status(8'h00, "R2 status bit7 low");
    read_data(8'hFE, "R2 ack byte");
    read_status(8'h80, "R7 status after read");
    bus_write(BASE, 8'h33);
    tx_settle_and_compare("R2 still command mode");

    // R2: entry command
    bus_write(BASE + 16'd1, 8'h3F);
    read_data(8'hFE, "R2 entry ack");

    // R4: transmit
    bus_write(BASE, 8'hA5);
    exp_tx.push_back(8'hA5);
    tx_settle_and_compare("R4 frame A5");
    bus_write(BASE, 8'h80);
    exp_tx.push_back(8'h80);
    tx_settle_and_compare("R4 frame 80");

    // R5: holding register, third write dropped
    bus_write(BASE, 8'h01);
    bus_write(BASE, 8'h02);
    read_status(8'hC0, "R5 not ready");
    bus_write(BASE, 8'h03);
    exp_tx.push_back(8'h01);
    exp_tx.push_back(8'h02);
    tx_settle_and_compare("R5 drop while full");
    read_status(8'h80, "R5 ready again");

    // R6/R7: receive
    send_serial(8'h3C, 1'b1);
    check(host_irq == 1'b1, "R6 irq", host_irq, 1);
    read_status(8'h00, "R6 status");
    read_data(8'h3C, "R6 data");
    check(host_irq == 1'b0, "R7 irq cleared", host_irq, 0);

    // R10: older byte kept
    send_serial(8'h11, 1'b1);
    send_serial(8'h22, 1'b1);
    read_data(8'h11, "R10 older kept");
    check(host_irq == 1'b0, "R10 newer dropped", host_irq, 0);

    // R8: other commands ignored in pass-through
    bus_write(BASE + 16'd1, 8'h3F);
    check(host_irq == 1'b0, "R8 no ack", host_irq, 0);
    bus_write(BASE + 16'd1, 8'h00);
    check(host_irq == 1'b0, "R8 no ack 00", host_irq, 0);
    bus_write(BASE, 8'h77);
    exp_tx.push_back(8'h77);
    tx_settle_and_compare("R8 mode unchanged");

    // R12: bad stop bit
    send_serial(8'h5A, 1'b0);
    check(host_irq == 1'b0, "R12 framing drop", host_irq, 0);
    send_serial(8'h6B, 1'b1);
    read_data(8'h6B, "R12 receiver recovers");

    // R11: other addresses
    bus_write(BASE + 16'd2, 8'h44);
    bus_write(BASE - 16'd1, 8'hFF);
    tx_settle_and_compare("R11 no tx from foreign address");
    bus_read(BASE + 16'd2, d, en);
    check(en == 1'b0, "R11 rd_en low", en, 0);
    check(host_irq == 1'b0, "R11 no ack", host_irq, 0);

    // R10/R9: ack overwrites pending byte, reset returns to command mode
    send_serial(8'h44, 1'b1);
    bus_write(BASE + 16'd1, 8'hFF);
    read_data(8'hFE, "R9 ack overwrites");
    bus_write(BASE, 8'h66);
    tx_settle_and_compare("R9 command mode after reset");
    send_serial(8'h21, 1'b1);
    check(host_irq == 1'b0, "R9 rx dropped in command mode", host_irq, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule